// File: doc/BRIEF.md
# Base Timer with Buzzer Tone Output

This block is a free-running 14-bit divider for clock-keeping work. Each cycle it may be advanced by one of three clock-enable ticks: a tick derived from a 32.768 kHz crystal, the system cycle tick, or the output tick of a neighbouring timer's prescaler. Software picks the tick with a two-bit source select. When the divider is stopped it returns to zero and stays there.

Two overflow flags are taken from fixed divider taps. The long flag marks every 16384 ticks, which is half a second from a 32.768 kHz source. The short flag marks one of four shorter periods: 32, 128, 512 or 2048 ticks, which is roughly 1 ms, 3.9 ms, 15.6 ms or 62.5 ms. Both flags stay set until software clears them. Each flag has its own enable, and the enabled flags are ORed into a single interrupt request. That request is meant to share an interrupt slot with an external pin interrupt.

A buzzer output carries a square wave at the tick rate divided by 8 or by 16, which is about 4 kHz or 2 kHz from the crystal. When the buzzer is disabled, its output is held low.

Top module: `base_tmr`

## Requirements
- R1: While reset is asserted (rstN low), shortFlag, longFlag, irq and buzzOut are all 0, and the divider is zero.
- R2: The divider advances by one on a clock edge only when runEn is 1 and the selected tick is 1. The source select encoding is: srcSel 0 uses tickSub, 1 uses tickSys, 2 uses tickPre, and 3 selects no tick, so the divider holds. Ticks that are not selected have no effect.
- R3: Counting from zero, shortFlag sets on the edge of the Nth advance and on every later multiple of N. N is 32, 128, 512 or 2048 for intervalSel 0, 1, 2 or 3.
- R4: Counting from zero, longFlag sets on the edge of the 16384th advance, where the divider wraps to zero.
- R5: A flag that is set stays set until its clear input (shortClr or longClr) is 1 at a clock edge. If the flag's set event and its clear fall on the same edge, the flag ends up set.
- R6: irq is 1 exactly when (shortFlag and shortIe) or (longFlag and longIe) is true.
- R7: With buzzEn 1, buzzOut is 1 when the advance count modulo P is at least P/2, where P is 8 for freqSel 0 and 16 for freqSel 1. With buzzEn 0, buzzOut is 0.
- R8: A clock edge with runEn 0 returns the divider to zero, so buzzOut is 0 afterwards. The flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickSub | input | 1 | 32.768 kHz crystal clock-enable tick |
| tickSys | input | 1 | System cycle clock-enable tick |
| tickPre | input | 1 | Prescaler tick from another timer |
| srcSel | input | 2 | Tick source select (0 crystal, 1 system, 2 prescaler, 3 none) |
| runEn | input | 1 | Run; 0 holds the divider at zero |
| intervalSel | input | 2 | Short period select (32/128/512/2048 ticks) |
| buzzEn | input | 1 | Buzzer enable |
| freqSel | input | 1 | Buzzer divide select (0: /8, 1: /16) |
| shortIe | input | 1 | Short flag interrupt enable |
| longIe | input | 1 | Long flag interrupt enable |
| shortClr | input | 1 | Clear short flag |
| longClr | input | 1 | Clear long flag |
| shortFlag | output | 1 | Sticky short overflow flag |
| longFlag | output | 1 | Sticky long overflow flag |
| irq | output | 1 | Interrupt request |
| buzzOut | output | 1 | Buzzer square wave |

## Verification
The hardest situation to reach from the ports is the long overflow, because it needs 16384 uninterrupted advances from a known zero state. A directed phase holds tickSys high with the timer running for that whole stretch, and samples longFlag one advance before the wrap and again on the wrap. The same-edge collision between a set event and a clear is also rare under random stimulus. The bench therefore stops the timer to reach zero, counts up to the advance just before a short wrap, and asserts the clear on exactly the wrapping edge. Random phases then mix sources, sparse ticks, stops and clears against a bench model that counts advances.

// File: rtl/base_tmr_pkg.sv
package base_tmr_pkg;
  typedef enum logic [1:0] {
    SRC_SUB  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_PRE  = 2'd2,
    SRC_NONE = 2'd3
  } tmrSrc_e;

  typedef struct packed {
    logic advance;
    logic zero;
    logic clrShort;
    logic clrLong;
  } tmrStrobe_t;
endpackage

// File: rtl/base_tmr_ctrl.sv
module base_tmr_ctrl
  import base_tmr_pkg::*;
(
  input  logic       tickSub,
  input  logic       tickSys,
  input  logic       tickPre,
  input  logic [1:0] srcSel,
  input  logic       runEn,
  input  logic       shortClr,
  input  logic       longClr,
  output tmrStrobe_t strb
);
  logic selTick;

  always_comb begin
    unique case (tmrSrc_e'(srcSel))
      SRC_SUB:  selTick = tickSub;
      SRC_SYS:  selTick = tickSys;
      SRC_PRE:  selTick = tickPre;
      default:  selTick = 1'b0;
    endcase
  end

  always_comb begin
    strb.advance  = runEn & selTick;
    strb.zero     = ~runEn;
    strb.clrShort = shortClr;
    strb.clrLong  = longClr;
  end
endmodule

// File: rtl/base_tmr_dp.sv
module base_tmr_dp
  import base_tmr_pkg::*;
#(
  parameter int DIV_W      = 14,
  parameter int SHORT_BASE = 5,
  parameter int SHORT_STEP = 2,
  parameter int SHORT_OPTS = 4,
  parameter int BUZZ_BASE  = 3,
  parameter int BUZZ_OPTS  = 2,
  localparam int SEL_W     = $clog2(SHORT_OPTS),
  localparam int BSEL_W    = $clog2(BUZZ_OPTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [SEL_W-1:0]  intervalSel,
  input  logic              buzzEn,
  input  logic [BSEL_W-1:0] freqSel,
  input  logic              shortIe,
  input  logic              longIe,
  output logic              shortFlag,
  output logic              longFlag,
  output logic              irq,
  output logic              buzzOut
);
  logic [DIV_W-1:0]      divCnt;
  logic [SHORT_OPTS-1:0] shortWrap;
  logic [BUZZ_OPTS-1:0]  buzzTap;
  logic                  longWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            divCnt <= '0;
    else if (strb.zero)   divCnt <= '0;
    else if (strb.advance) divCnt <= divCnt + 1'b1;
  end

  // Each short option wraps when its low bits are all ones at an advance.
  for (genvar k = 0; k < SHORT_OPTS; k++) begin : g_short
    localparam int TAPW = SHORT_BASE + SHORT_STEP * k;
    assign shortWrap[k] = &divCnt[TAPW-1:0];
  end

  for (genvar b = 0; b < BUZZ_OPTS; b++) begin : g_buzz
    assign buzzTap[b] = divCnt[BUZZ_BASE-1+b];
  end

  assign longWrap = &divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortFlag <= 1'b0;
      longFlag  <= 1'b0;
    end else begin
      if (strb.advance && shortWrap[intervalSel]) shortFlag <= 1'b1;
      else if (strb.clrShort)                     shortFlag <= 1'b0;
      if (strb.advance && longWrap)               longFlag  <= 1'b1;
      else if (strb.clrLong)                      longFlag  <= 1'b0;
    end
  end

  assign irq     = (shortFlag & shortIe) | (longFlag & longIe);
  assign buzzOut = buzzEn & buzzTap[freqSel];
endmodule

// File: rtl/base_tmr.sv
module base_tmr
  import base_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickSub,
  input  logic       tickSys,
  input  logic       tickPre,
  input  logic [1:0] srcSel,
  input  logic       runEn,
  input  logic [1:0] intervalSel,
  input  logic       buzzEn,
  input  logic       freqSel,
  input  logic       shortIe,
  input  logic       longIe,
  input  logic       shortClr,
  input  logic       longClr,
  output logic       shortFlag,
  output logic       longFlag,
  output logic       irq,
  output logic       buzzOut
);
  tmrStrobe_t strb;

  base_tmr_ctrl u_ctrl (
    .tickSub (tickSub),
    .tickSys (tickSys),
    .tickPre (tickPre),
    .srcSel  (srcSel),
    .runEn   (runEn),
    .shortClr(shortClr),
    .longClr (longClr),
    .strb    (strb)
  );

  base_tmr_dp #(
    .DIV_W     (14),
    .SHORT_BASE(5),
    .SHORT_STEP(2),
    .SHORT_OPTS(4),
    .BUZZ_BASE (3),
    .BUZZ_OPTS (2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .intervalSel(intervalSel),
    .buzzEn     (buzzEn),
    .freqSel    (freqSel),
    .shortIe    (shortIe),
    .longIe     (longIe),
    .shortFlag  (shortFlag),
    .longFlag   (longFlag),
    .irq        (irq),
    .buzzOut    (buzzOut)
  );
endmodule

// File: rtl/base_tmr_chk.sv
module base_tmr_chk (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic buzzEn,
  input logic shortIe,
  input logic longIe,
  input logic shortClr,
  input logic longClr,
  input logic shortFlag,
  input logic longFlag,
  input logic irq,
  input logic buzzOut
);
  p_short_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    shortFlag && !shortClr |=> shortFlag);

  p_long_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    longFlag && !longClr |=> longFlag);

  p_short_needs_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shortFlag) |-> $past(runEn));

  p_long_needs_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(longFlag) |-> $past(runEn));

  p_no_irq_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    !shortIe && !longIe |-> !irq);

  p_buzz_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !buzzEn |-> !buzzOut);

  p_stop_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !buzzOut);
endmodule

bind base_tmr base_tmr_chk u_chk (.*);

// File: tb/sim_base_tmr.sv
`timescale 1ns/1ps
module sim_base_tmr;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickSub = 0, tickSys = 0, tickPre = 0;
  logic [1:0] srcSel = 0, intervalSel = 0;
  logic runEn = 0, buzzEn = 0, freqSel = 0, shortIe = 0, longIe = 0;
  logic shortClr = 0, longClr = 0;
  logic shortFlag, longFlag, irq, buzzOut;

  int nChecks = 0;
  int nFails = 0;
  int mCnt = 0;
  logic mShort = 0, mLong = 0;

  always #2 clk = ~clk;

  base_tmr u0 (.*);

  function automatic int shortDiv(input logic [1:0] s);
    return 32 << (2 * s);
  endfunction

  function automatic logic expBuzz(input int c, input logic en, input logic f);
    int p;
    p = f ? 16 : 8;
    return en && ((c % p) >= p / 2);
  endfunction

  task automatic chk(input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic cycle();
    logic tk, evS, evL;
    @(posedge clk);
    evS = 0; evL = 0;
    if (!rstN) begin
      mCnt = 0; mShort = 0; mLong = 0;
    end else begin
      tk = runEn && ((srcSel == 2'd0 && tickSub) || (srcSel == 2'd1 && tickSys) ||
                     (srcSel == 2'd2 && tickPre));
      if (!runEn) mCnt = 0;
      else if (tk) begin
        mCnt = (mCnt + 1) % 16384;
        evS = (mCnt % shortDiv(intervalSel)) == 0;
        evL = (mCnt == 0);
      end
      if (evS) mShort = 1; else if (shortClr) mShort = 0;
      if (evL) mLong = 1;  else if (longClr) mLong = 0;
    end
    @(negedge clk);
    chk("R3 shortFlag", shortFlag, mShort);
    chk("R4 longFlag", longFlag, mLong);
    chk("R6 irq", irq, (mShort && shortIe) || (mLong && longIe));
    chk("R7 buzzOut", buzzOut, expBuzz(mCnt, buzzEn, freqSel));
  endtask

  task automatic restart();
    runEn = 0; shortClr = 1; longClr = 1;
    cycle();
    shortClr = 0; longClr = 0; runEn = 1;
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    tickSys = 1; runEn = 1; buzzEn = 1; shortIe = 1; longIe = 1; srcSel = 1;
    repeat (3) cycle();
    chk("R1 shortFlag in reset", shortFlag, 1'b0);
    chk("R1 longFlag in reset", longFlag, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 buzzOut in reset", buzzOut, 1'b0);
    rstN = 1;
    restart();
    buzzEn = 0;

    // R3: exact 32-advance period
    repeat (31) cycle();
    chk("R3 short before 32", shortFlag, 1'b0);
    cycle();
    chk("R3 short at 32", shortFlag, 1'b1);
    chk("R6 irq with short", irq, 1'b1);

    // R5: clear, then collide clear with set at advance 64
    shortClr = 1; cycle(); shortClr = 0;
    chk("R5 short cleared", shortFlag, 1'b0);
    while (mCnt != 63) cycle();
    shortClr = 1; cycle(); shortClr = 0;
    chk("R5 set wins over clear", shortFlag, 1'b1);
    repeat (5) cycle();
    chk("R5 sticky", shortFlag, 1'b1);

    // R8: stop zeroes divider, flags kept
    buzzEn = 1; freqSel = 0;
    while (mCnt % 8 < 4) cycle();
    runEn = 0; cycle();
    chk("R8 buzz low after stop", buzzOut, 1'b0);
    chk("R8 flag kept on stop", shortFlag, 1'b1);
    restart();
    repeat (3) cycle();
    chk("R7 buzz low at 3", buzzOut, 1'b0);
    cycle();
    chk("R7 buzz high at 4", buzzOut, 1'b1);
    repeat (4) cycle();
    chk("R7 buzz low at 8", buzzOut, 1'b0);
    freqSel = 1; buzzEn = 0;
    repeat (4) cycle();
    chk("R7 disabled buzz low", buzzOut, 1'b0);
    buzzEn = 1;

    // R2: no tick source, then crystal pulses with system tick ignored
    restart();
    srcSel = 3;
    repeat (100) cycle();
    chk("R2 no-source holds", shortFlag, 1'b0);
    srcSel = 0;
    for (int i = 0; i < 32; i++) begin
      if (i == 31) chk("R2 sub before 32 pulses", shortFlag, 1'b0);
      tickSub = 1; cycle(); tickSub = 0;
      repeat (3) cycle();
    end
    chk("R2 sub 32 pulses", shortFlag, 1'b1);

    // R4: long overflow with 2048 short period
    srcSel = 1; intervalSel = 3;
    restart();
    repeat (16383) cycle();
    chk("R4 long before wrap", longFlag, 1'b0);
    cycle();
    chk("R4 long at wrap", longFlag, 1'b1);
    shortIe = 0;
    chk("R6 irq from long", irq, 1'b1);
    longIe = 0;
    #0;
    chk("R6 irq masked", irq, 1'b0);

    // Random mix
    for (int n = 0; n < 20000; n++) begin
      runEn   = ($urandom % 64) != 0;
      srcSel  = 2'($urandom % 4);
      tickSub = ($urandom % 4) == 0;
      tickSys = ($urandom % 8) != 0;
      tickPre = ($urandom % 2) == 0;
      shortClr = ($urandom % 150) == 0;
      longClr  = ($urandom % 150) == 0;
      if (n % 97 == 0) begin
        intervalSel = 2'($urandom % 2);
        buzzEn  = 1'($urandom);
        freqSel = 1'($urandom);
        shortIe = 1'($urandom);
        longIe  = 1'($urandom);
      end
      cycle();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule